// File: doc/BRIEF.md
# Character-Cell Raster Timing Controller

This block generates the video timing and the refresh memory addresses for a text or semi-graphic raster display built from character cells. A processor programs the frame geometry through a small indexed register bus. The geometry covers the line length, the visible characters per line, the sync positions and widths, the scan lines per character row, the rows per frame, the extra adjust lines and interlace. The block then produces horizontal sync, vertical sync, display enable, a cursor strobe, a 14-bit refresh address and a 5-bit scan-line (row) address. All of these are timed from the character clock.

The refresh address is a linear walk through character memory. Each frame begins at a programmable start address, so rewriting that address scrolls the picture by a whole page or by one character. The address keeps moving through blanking and retrace, so dynamic memory behind it stays refreshed. A cursor with a programmable scan-line span and blink rate is flagged where the address meets the cursor position. A light pen strobe captures the refresh address, offset by two, into a readable register.

Top module: `crt_raster_timer`

## Requirements
- R1: After reset every output is low or zero and every readable register returns 0.
- R2: A bus write (busEn=1, busCs=1, busRw=0) with busRs=0 loads bits 4:0 of busDin into the index. With busRs=1 the write stores busDin into the indexed register. A read (busEn=1, busCs=1, busRw=1, busRs=1) returns the indexed register, and busDout is 0 at all other times. The index map is: 0 line total, 1 visible characters, 2 hsync position, 3 sync widths (bits 3:0 horizontal, bits 7:4 vertical), 4 row total (7 bits), 5 adjust lines (5 bits), 6 visible rows (7 bits), 7 vsync row (7 bits), 8 mode (bit 0 interlace), 9 last scan line of a row (5 bits), 10 cursor top line (bits 4:0) with blink mode (bits 6:5), 11 cursor bottom line (5 bits), 12/13 start address high (6 bits)/low, 14/15 cursor address high (6 bits)/low, 16/17 light pen high/low (read-only). Unused bits read 0, and indices 18 and above read 0 and ignore writes.
- R3: The character count runs from 0 to the line total and then wraps to 0. displayEnable is high exactly when the count is below the visible characters, the row is below the visible rows, and the line is not an adjust line.
- R4: hSync is high for a number of characters equal to the horizontal width, starting at the hsync position. A width of 0 gives no pulse.
- R5: rowAddr counts the scan lines 0 to the last scan line within each row. Rows run 0 to the row total, and then the adjust lines follow with rowAddr counting up from 0. A frame with no adjust lines ends right after the last row.
- R6: refreshAddr equals the row start plus the character count, modulo 2^14, on every clock, including retrace. The row start loads the start address when a frame ends and grows by the visible characters at the end of every other row.
- R7: vSync rises one clock after character count 0 of scan line 0 of the vsync row. It stays high for a number of scan lines equal to the vertical width, and a width of 0 gives no pulse.
- R8: With interlace on, the field flips at every frame end. In odd fields both vSync edges move to one clock after character count (line total >> 1).
- R9: cursor is high exactly when displayEnable is high, refreshAddr equals the cursor address, rowAddr lies between the cursor top and bottom lines, and blink allows it.
- R10: The blink modes are 0 always shown, 1 never shown, 2 shown while bit 3 of the frame counter is 0, and 3 shown while bit 4 of the frame counter is 0. The frame counter is 5 bits wide and is incremented at each frame end.
- R11: At the first clock edge where penStrobe is sampled high after being sampled low, the light pen register takes refreshAddr + 2, modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busCs | input | 1 | Register bus chip select |
| busRs | input | 1 | 0 selects the index, 1 selects the indexed register |
| busRw | input | 1 | 1 read, 0 write |
| busEn | input | 1 | Bus enable strobe |
| busDin | input | 8 | Write data |
| busDout | output | 8 | Read data |
| penStrobe | input | 1 | Light pen strobe |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| displayEnable | output | 1 | Active video area |
| cursor | output | 1 | Cursor strobe |
| refreshAddr | output | 14 | Refresh memory address |
| rowAddr | output | 5 | Scan line within the character row |

## Verification
A behavioural frame model is compared with every output on each clock. The stimulus sets the start address just below the top of the 14-bit space, so row starts and in-line addresses wrap. It then changes the start address mid-run, which exposes any error in the carry or the reload order. Each blink mode runs over windows that span many frames, so the steady, hidden, fast and slow phases can be told apart. An exact cursor count over two whole frames pins the scan-line span. Interlace, a zero vertical width, adjust lines present and absent, and a one-line character row move the vsync edges and the frame end in different ways. Light pen pulses are checked against addresses sampled at the ports.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 14;
  localparam int RA_W    = 5;
  localparam int HC_W    = 8;
  localparam int VR_W    = 7;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 5;
  localparam int SW_W    = 4;
  localparam int FRAME_W = 5;
  localparam int FAST_BIT = 3;
  localparam int SLOW_BIT = 4;

  localparam logic [IDX_W-1:0] REG_HTOTAL   = 5'd0;
  localparam logic [IDX_W-1:0] REG_HDISP    = 5'd1;
  localparam logic [IDX_W-1:0] REG_HSYNC    = 5'd2;
  localparam logic [IDX_W-1:0] REG_SYNCW    = 5'd3;
  localparam logic [IDX_W-1:0] REG_VTOTAL   = 5'd4;
  localparam logic [IDX_W-1:0] REG_VADJ     = 5'd5;
  localparam logic [IDX_W-1:0] REG_VDISP    = 5'd6;
  localparam logic [IDX_W-1:0] REG_VSYNC    = 5'd7;
  localparam logic [IDX_W-1:0] REG_MODE     = 5'd8;
  localparam logic [IDX_W-1:0] REG_MAXSCAN  = 5'd9;
  localparam logic [IDX_W-1:0] REG_CURTOP   = 5'd10;
  localparam logic [IDX_W-1:0] REG_CURBOT   = 5'd11;
  localparam logic [IDX_W-1:0] REG_STARTHI  = 5'd12;
  localparam logic [IDX_W-1:0] REG_STARTLO  = 5'd13;
  localparam logic [IDX_W-1:0] REG_CURHI    = 5'd14;
  localparam logic [IDX_W-1:0] REG_CURLO    = 5'd15;
  localparam logic [IDX_W-1:0] REG_PENHI    = 5'd16;
  localparam logic [IDX_W-1:0] REG_PENLO    = 5'd17;

  typedef enum logic [1:0] {
    BLINK_STEADY = 2'd0,
    BLINK_OFF    = 2'd1,
    BLINK_FAST   = 2'd2,
    BLINK_SLOW   = 2'd3
  } blink_e;

  typedef struct packed {
    logic [HC_W-1:0]  hTotal;
    logic [HC_W-1:0]  hDisp;
    logic [HC_W-1:0]  hSyncPos;
    logic [SW_W-1:0]  hSyncWidth;
    logic [SW_W-1:0]  vSyncWidth;
    logic [VR_W-1:0]  vTotal;
    logic [RA_W-1:0]  vAdjust;
    logic [VR_W-1:0]  vDisp;
    logic [VR_W-1:0]  vSyncRow;
    logic             interlace;
    logic [RA_W-1:0]  maxScan;
    blink_e           blinkMode;
  } rtcTiming_t;

  typedef struct packed {
    logic [ADDR_W-1:0] startAddr;
    logic [ADDR_W-1:0] cursorAddr;
    logic [RA_W-1:0]   curTop;
    logic [RA_W-1:0]   curBot;
  } rtcAddr_t;

  typedef struct packed {
    logic rowAdvance;
    logic frameReload;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCs,
  input  logic              busRs,
  input  logic              busRw,
  input  logic              busEn,
  input  logic [DATA_W-1:0] busDin,
  output logic [DATA_W-1:0] busDout,
  input  logic [ADDR_W-1:0] penAddr,
  output rtcTiming_t        timing,
  output rtcAddr_t          addrCfg
);
  localparam int HI_W = ADDR_W - 8;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] regRead;
  logic              writeStb;
  logic              readStb;

  assign writeStb = busEn && busCs && !busRw;
  assign readStb  = busEn && busCs && busRw && busRs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      timing  <= '0;
      addrCfg <= '0;
    end else if (writeStb) begin
      if (!busRs) begin
        idx <= busDin[IDX_W-1:0];
      end else begin
        case (idx)
          REG_HTOTAL:  timing.hTotal   <= busDin;
          REG_HDISP:   timing.hDisp    <= busDin;
          REG_HSYNC:   timing.hSyncPos <= busDin;
          REG_SYNCW: begin
            timing.hSyncWidth <= busDin[SW_W-1:0];
            timing.vSyncWidth <= busDin[2*SW_W-1:SW_W];
          end
          REG_VTOTAL:  timing.vTotal    <= busDin[VR_W-1:0];
          REG_VADJ:    timing.vAdjust   <= busDin[RA_W-1:0];
          REG_VDISP:   timing.vDisp     <= busDin[VR_W-1:0];
          REG_VSYNC:   timing.vSyncRow  <= busDin[VR_W-1:0];
          REG_MODE:    timing.interlace <= busDin[0];
          REG_MAXSCAN: timing.maxScan   <= busDin[RA_W-1:0];
          REG_CURTOP: begin
            addrCfg.curTop   <= busDin[RA_W-1:0];
            timing.blinkMode <= blink_e'(busDin[RA_W+1:RA_W]);
          end
          REG_CURBOT:  addrCfg.curBot <= busDin[RA_W-1:0];
          REG_STARTHI: addrCfg.startAddr[ADDR_W-1:8]  <= busDin[HI_W-1:0];
          REG_STARTLO: addrCfg.startAddr[7:0]         <= busDin;
          REG_CURHI:   addrCfg.cursorAddr[ADDR_W-1:8] <= busDin[HI_W-1:0];
          REG_CURLO:   addrCfg.cursorAddr[7:0]        <= busDin;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRead = '0;
    case (idx)
      REG_HTOTAL:  regRead = timing.hTotal;
      REG_HDISP:   regRead = timing.hDisp;
      REG_HSYNC:   regRead = timing.hSyncPos;
      REG_SYNCW:   regRead = {timing.vSyncWidth, timing.hSyncWidth};
      REG_VTOTAL:  regRead = {{(DATA_W-VR_W){1'b0}}, timing.vTotal};
      REG_VADJ:    regRead = {{(DATA_W-RA_W){1'b0}}, timing.vAdjust};
      REG_VDISP:   regRead = {{(DATA_W-VR_W){1'b0}}, timing.vDisp};
      REG_VSYNC:   regRead = {{(DATA_W-VR_W){1'b0}}, timing.vSyncRow};
      REG_MODE:    regRead = {{(DATA_W-1){1'b0}}, timing.interlace};
      REG_MAXSCAN: regRead = {{(DATA_W-RA_W){1'b0}}, timing.maxScan};
      REG_CURTOP:  regRead = {{(DATA_W-RA_W-2){1'b0}}, timing.blinkMode, addrCfg.curTop};
      REG_CURBOT:  regRead = {{(DATA_W-RA_W){1'b0}}, addrCfg.curBot};
      REG_STARTHI: regRead = {{(DATA_W-HI_W){1'b0}}, addrCfg.startAddr[ADDR_W-1:8]};
      REG_STARTLO: regRead = addrCfg.startAddr[7:0];
      REG_CURHI:   regRead = {{(DATA_W-HI_W){1'b0}}, addrCfg.cursorAddr[ADDR_W-1:8]};
      REG_CURLO:   regRead = addrCfg.cursorAddr[7:0];
      REG_PENHI:   regRead = {{(DATA_W-HI_W){1'b0}}, penAddr[ADDR_W-1:8]};
      REG_PENLO:   regRead = penAddr[7:0];
      default:     regRead = '0;
    endcase
  end

  assign busDout = readStb ? regRead : '0;

  // R2: an index write is visible on the following clock
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rstN)
    (writeStb && !busRs) |=> (idx == $past(busDin[IDX_W-1:0])));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  rtcTiming_t      timing,
  output logic [HC_W-1:0] hCount,
  output logic [RA_W-1:0] scan,
  output logic            displayEnable,
  output logic            hSync,
  output logic            vSync,
  output logic            blinkOn,
  output rtcStrobe_t      strobe
);
  logic [VR_W-1:0]    row;
  logic               inAdjust;
  logic               field;
  logic [FRAME_W-1:0] frameCount;
  logic               vsActive;
  logic [SW_W-1:0]    vsLeft;

  logic lineEnd, lastScan, rowEnd, frameEnd, enterAdjust;
  logic oddField, vsTrig, syncLine;
  logic [HC_W:0] hDiff;

  assign lineEnd     = (hCount == timing.hTotal);
  assign lastScan    = (scan == timing.maxScan);
  assign rowEnd      = lineEnd && !inAdjust && lastScan;
  assign frameEnd    = lineEnd && (inAdjust ? (scan == timing.vAdjust - RA_W'(1))
                                            : (lastScan && row == timing.vTotal && timing.vAdjust == '0));
  assign enterAdjust = rowEnd && (row == timing.vTotal) && (timing.vAdjust != '0);

  assign strobe.rowAdvance  = rowEnd && !frameEnd;
  assign strobe.frameReload = frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount     <= '0;
      scan       <= '0;
      row        <= '0;
      inAdjust   <= 1'b0;
      field      <= 1'b0;
      frameCount <= '0;
    end else begin
      hCount <= lineEnd ? '0 : hCount + HC_W'(1);
      if (frameEnd) begin
        row        <= '0;
        scan       <= '0;
        inAdjust   <= 1'b0;
        field      <= timing.interlace ? !field : 1'b0;
        frameCount <= frameCount + FRAME_W'(1);
      end else if (enterAdjust) begin
        inAdjust <= 1'b1;
        scan     <= '0;
      end else if (rowEnd) begin
        scan <= '0;
        row  <= row + VR_W'(1);
      end else if (lineEnd) begin
        scan <= scan + RA_W'(1);
      end
    end
  end

  // vertical sync: edges land on the line start, or mid-line in odd fields
  assign oddField = field && timing.interlace;
  assign vsTrig   = oddField ? (hCount == (timing.hTotal >> 1)) : (hCount == '0);
  assign syncLine = !inAdjust && (row == timing.vSyncRow) && (scan == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsActive <= 1'b0;
      vsLeft   <= '0;
    end else if (vsTrig) begin
      if (vsActive) begin
        if (vsLeft <= SW_W'(1)) vsActive <= 1'b0;
        else                    vsLeft   <= vsLeft - SW_W'(1);
      end else if (syncLine && timing.vSyncWidth != '0) begin
        vsActive <= 1'b1;
        vsLeft   <= timing.vSyncWidth;
      end
    end
  end

  assign vSync = vsActive;

  assign hDiff = {1'b0, hCount} - {1'b0, timing.hSyncPos};
  assign hSync = (hCount >= timing.hSyncPos) &&
                 (hDiff < {{(HC_W+1-SW_W){1'b0}}, timing.hSyncWidth});

  assign displayEnable = (hCount < timing.hDisp) && (row < timing.vDisp) && !inAdjust;

  always_comb begin
    case (timing.blinkMode)
      BLINK_STEADY: blinkOn = 1'b1;
      BLINK_OFF:    blinkOn = 1'b0;
      BLINK_FAST:   blinkOn = !frameCount[FAST_BIT];
      BLINK_SLOW:   blinkOn = !frameCount[SLOW_BIT];
      default:      blinkOn = 1'b0;
    endcase
  end

  // R3: the line counter restarts after the last character
  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> (hCount == '0));
  // R5: a frame end returns to the first scan line of row 0
  a_r5_frame_restart: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (row == '0 && scan == '0 && !inAdjust));
  // R7: vsync only starts at a trigger point on the sync row
  a_r7_vsync_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vSync) |-> $past(vsTrig && syncLine));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcAddr_t          addrCfg,
  input  logic [HC_W-1:0]   rowStride,
  input  rtcStrobe_t        strobe,
  input  logic [HC_W-1:0]   hCount,
  input  logic [RA_W-1:0]   scan,
  input  logic              displayEnable,
  input  logic              blinkOn,
  input  logic              penStrobe,
  output logic [ADDR_W-1:0] refAddr,
  output logic              cursorOut,
  output logic [ADDR_W-1:0] penAddr
);
  logic [ADDR_W-1:0] rowStart;
  logic              penPrev;
  logic              penCapture;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowStart <= '0;
    end else if (strobe.frameReload) begin
      rowStart <= addrCfg.startAddr;
    end else if (strobe.rowAdvance) begin
      rowStart <= rowStart + {{(ADDR_W-HC_W){1'b0}}, rowStride};
    end
  end

  assign refAddr = rowStart + {{(ADDR_W-HC_W){1'b0}}, hCount};

  assign cursorOut = displayEnable && blinkOn && (refAddr == addrCfg.cursorAddr) &&
                     (scan >= addrCfg.curTop) && (scan <= addrCfg.curBot);

  assign penCapture = penStrobe && !penPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      penPrev <= 1'b0;
      penAddr <= '0;
    end else begin
      penPrev <= penStrobe;
      if (penCapture) penAddr <= refAddr + ADDR_W'(2);
    end
  end

  // R6: frame start takes the programmed start address
  a_r6_row_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameReload |=> (rowStart == $past(addrCfg.startAddr)));
  // R11: the pen register holds the address two beyond the sampled one
  a_r11_pen_offset: assert property (@(posedge clk) disable iff (!rstN)
    penCapture |=> (penAddr == $past(refAddr) + ADDR_W'(2)));
endmodule

// File: rtl/crt_raster_timer.sv
module crt_raster_timer
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCs,
  input  logic              busRs,
  input  logic              busRw,
  input  logic              busEn,
  input  logic [DATA_W-1:0] busDin,
  output logic [DATA_W-1:0] busDout,
  input  logic              penStrobe,
  output logic              hSync,
  output logic              vSync,
  output logic              displayEnable,
  output logic              cursor,
  output logic [ADDR_W-1:0] refreshAddr,
  output logic [RA_W-1:0]   rowAddr
);
  rtcTiming_t        timing;
  rtcAddr_t          addrCfg;
  rtcStrobe_t        strobe;
  logic [HC_W-1:0]   hCount;
  logic              blinkOn;
  logic [ADDR_W-1:0] penAddr;

  rtc_regs u_regs (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busRs(busRs), .busRw(busRw),
    .busEn(busEn), .busDin(busDin), .busDout(busDout), .penAddr(penAddr),
    .timing(timing), .addrCfg(addrCfg)
  );

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .timing(timing), .hCount(hCount), .scan(rowAddr),
    .displayEnable(displayEnable), .hSync(hSync), .vSync(vSync),
    .blinkOn(blinkOn), .strobe(strobe)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .addrCfg(addrCfg), .rowStride(timing.hDisp),
    .strobe(strobe), .hCount(hCount), .scan(rowAddr),
    .displayEnable(displayEnable), .blinkOn(blinkOn), .penStrobe(penStrobe),
    .refAddr(refreshAddr), .cursorOut(cursor), .penAddr(penAddr)
  );
endmodule

// File: tb/crt_raster_timer_bench.sv
module crt_raster_timer_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        busCs = 0, busRs = 0, busRw = 0, busEn = 0;
  logic [7:0]  busDin = '0;
  logic [7:0]  busDout;
  logic        penStrobe = 0;
  logic        hSync, vSync, displayEnable, cursor;
  logic [13:0] refreshAddr;
  logic [4:0]  rowAddr;

  crt_raster_timer u_crt_raster_timer (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busRs(busRs), .busRw(busRw),
    .busEn(busEn), .busDin(busDin), .busDout(busDout), .penStrobe(penStrobe),
    .hSync(hSync), .vSync(vSync), .displayEnable(displayEnable),
    .cursor(cursor), .refreshAddr(refreshAddr), .rowAddr(rowAddr)
  );

  int checks = 0, fails = 0, cycles = 0, curHits = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural frame model ----------------
  int mreg[0:31];
  int mh, msc, mrow, madj, mrs, mfld, mfc, mvsA, mvsL, mpp, mpen, midx;

  function automatic int maskOf(int i);
    case (i)
      4, 6, 7: return 127;
      5, 9, 11: return 31;
      8: return 1;
      10: return 127;
      12, 14: return 63;
      default: return 255;
    endcase
  endfunction

  function automatic int mMa();
    return (mrs + mh) % 16384;
  endfunction
  function automatic int mDe();
    return (mh < mreg[1] && mrow < mreg[6] && madj == 0) ? 1 : 0;
  endfunction
  function automatic int mHs();
    return (mh >= mreg[2] && (mh - mreg[2]) < (mreg[3] % 16)) ? 1 : 0;
  endfunction
  function automatic int mBlink();
    case (mreg[10] / 32)
      0: return 1;
      1: return 0;
      2: return ((mfc / 8) % 2 == 0) ? 1 : 0;
      default: return ((mfc / 16) % 2 == 0) ? 1 : 0;
    endcase
  endfunction
  function automatic int mCur();
    int ca = mreg[14] * 256 + mreg[15];
    return (mDe() == 1 && mBlink() == 1 && mMa() == ca &&
            msc >= mreg[10] % 32 && msc <= mreg[11]) ? 1 : 0;
  endfunction
  function automatic int expRead(int i);
    if (i <= 15) return mreg[i];
    if (i == 16) return mpen / 256;
    if (i == 17) return mpen % 256;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mreg[i] = 0;
      mh = 0; msc = 0; mrow = 0; madj = 0; mrs = 0; mfld = 0; mfc = 0;
      mvsA = 0; mvsL = 0; mpp = 0; mpen = 0; midx = 0;
    end else begin
      int hT, vA, lineEnd, rowEnd, frameEnd, enterAdj, trig, syncLine, vsw, sa;
      hT = mreg[0]; vA = mreg[5]; vsw = mreg[3] / 16;
      sa = mreg[12] * 256 + mreg[13];
      lineEnd  = (mh == hT);
      rowEnd   = (lineEnd && madj == 0 && msc == mreg[9]);
      frameEnd = lineEnd && (madj != 0 ? (msc == (vA + 31) % 32)
                                       : (msc == mreg[9] && mrow == mreg[4] && vA == 0));
      enterAdj = rowEnd && mrow == mreg[4] && vA != 0;
      // light pen
      if (penStrobe && mpp == 0) mpen = (mMa() + 2) % 16384;
      mpp = penStrobe;
      // vertical sync
      trig = (mfld != 0 && mreg[8] == 1) ? (mh == hT / 2) : (mh == 0);
      syncLine = (madj == 0 && mrow == mreg[7] && msc == 0);
      if (trig) begin
        if (mvsA != 0) begin
          if (mvsL <= 1) mvsA = 0; else mvsL = mvsL - 1;
        end else if (syncLine && vsw != 0) begin
          mvsA = 1; mvsL = vsw;
        end
      end
      // row start
      if (frameEnd) mrs = sa;
      else if (rowEnd) mrs = (mrs + mreg[1]) % 16384;
      // counters
      mh = lineEnd ? 0 : (mh + 1) % 256;
      if (frameEnd) begin
        mrow = 0; msc = 0; madj = 0;
        mfld = (mreg[8] == 1) ? 1 - mfld : 0;
        mfc = (mfc + 1) % 32;
      end else if (enterAdj) begin
        madj = 1; msc = 0;
      end else if (rowEnd) begin
        msc = 0; mrow = (mrow + 1) % 128;
      end else if (lineEnd) begin
        msc = (msc + 1) % 32;
      end
      // register bus
      if (busEn && busCs && !busRw) begin
        if (!busRs) midx = busDin % 32;
        else if (midx <= 15) mreg[midx] = busDin & maskOf(midx);
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6", refreshAddr, mMa(), "refreshAddr");
      check("R3", displayEnable, mDe(), "displayEnable");
      check("R4", hSync, mHs(), "hSync");
      check((mreg[8] == 1) ? "R8" : "R7", vSync, mvsA, "vSync");
      check("R5", rowAddr, msc, "rowAddr");
      check("R9", cursor, mCur(), "cursor");
      if (cursor) curHits++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic busWrite(int i, int v);
    @(negedge clk); busCs = 1; busEn = 1; busRw = 0; busRs = 0; busDin = 8'(i);
    @(negedge clk); busRs = 1; busDin = 8'(v);
    @(negedge clk); busEn = 0; busCs = 0; busRs = 0; busDin = '0;
  endtask

  task automatic busRead(int i, string req, output int val);
    @(negedge clk); busCs = 1; busEn = 1; busRw = 0; busRs = 0; busDin = 8'(i);
    @(negedge clk); busRw = 1; busRs = 1; busDin = '0;
    #1;
    val = busDout;
    check(req, busDout, expRead(i), $sformatf("readback of index %0d", i));
    @(negedge clk); busEn = 0; busCs = 0; busRw = 0; busRs = 0;
  endtask

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic penPulse();
    int expAddr, hi, lo;
    @(negedge clk); penStrobe = 1; #1;
    expAddr = (refreshAddr + 2) % 16384;
    runCycles(3);
    penStrobe = 0;
    runCycles(2);
    busRead(16, "R11", hi);
    busRead(17, "R11", lo);
    check("R11", hi * 256 + lo, expAddr, "pen latch from sampled address");
  endtask

  localparam int FRAME_A = 12 * (5 * 3 + 2);

  initial begin
    int v;
    runCycles(3);
    rstN = 1;
    #1;
    // R1: reset state at the ports
    check("R1", hSync, 0, "hSync after reset");
    check("R1", vSync, 0, "vSync after reset");
    check("R1", displayEnable, 0, "displayEnable after reset");
    check("R1", cursor, 0, "cursor after reset");
    check("R1", refreshAddr, 0, "refreshAddr after reset");
    check("R1", rowAddr, 0, "rowAddr after reset");
    for (int i = 0; i < 18; i++) begin
      busRead(i, "R1", v);
      check("R1", v, 0, "register zero after reset");
    end

    // geometry A: 12-char lines, 8 visible, rows of 3 lines, 5 rows + 2 adjust
    busWrite(0, 11);  busWrite(1, 8);  busWrite(2, 9);  busWrite(3, 8'h22);
    busWrite(4, 8'h84); busWrite(5, 2); busWrite(6, 3);  busWrite(7, 3);
    busWrite(8, 0);   busWrite(9, 2);  busWrite(10, 8'h41); busWrite(11, 2);
    busWrite(12, 8'h3F); busWrite(13, 8'hF0); busWrite(14, 8'h3F); busWrite(15, 8'hF3);
    busRead(4, "R2", v);  check("R2", v, 4, "row total masked to 7 bits");
    busRead(10, "R2", v); check("R2", v, 8'h41, "cursor top and blink");
    busRead(3, "R2", v);  check("R2", v, 8'h22, "sync widths");
    busWrite(16, 8'h55);
    busRead(16, "R2", v); check("R2", v, 0, "pen register ignores writes");
    busWrite(20, 7);
    busRead(20, "R2", v); check("R2", v, 0, "unused index reads zero");

    // R10 fast blink over 20 frames
    curHits = 0; runCycles(FRAME_A * 20);
    check("R10", (curHits > 0) ? 1 : 0, 1, "fast blink shows cursor");
    // R10 hidden
    busWrite(10, 8'h21);
    curHits = 0; runCycles(FRAME_A * 3);
    check("R10", curHits, 0, "hidden cursor count");
    // R9 steady: two scan lines of one cell per frame
    busWrite(10, 8'h01);
    curHits = 0; runCycles(FRAME_A * 2);
    check("R9", curHits, 4, "steady cursor hits over two frames");
    // R10 slow blink
    busWrite(10, 8'h61);
    curHits = 0; runCycles(FRAME_A * 70);
    check("R10", (curHits > 0) ? 1 : 0, 1, "slow blink shows cursor");

    penPulse();
    runCycles(57);
    penPulse();

    // R6 scroll to a new start address
    busWrite(12, 8'h01); busWrite(13, 8'h00);
    runCycles(FRAME_A * 3);
    // R8 interlace
    busWrite(8, 1);
    runCycles(FRAME_A * 6);
    busRead(8, "R8", v); check("R8", v, 1, "interlace bit");
    // R7 zero vertical width
    busWrite(3, 8'h02);
    runCycles(FRAME_A * 2);
    // R5 one-line rows, no adjust lines, odd half point
    busWrite(3, 8'h13); busWrite(8, 0); busWrite(5, 0); busWrite(9, 0); busWrite(0, 20);
    runCycles(21 * 5 * 8);
    penPulse();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule